// File: doc/BRIEF.md
# Device Power State Gating Controller

This block sits in front of a host controller function and holds its device power state. Only two states exist: fully on (D0) and powered down (D3). Software changes the state through a small configuration write port. Codes for the intermediate states are dropped without an error. Leaving D3 for D0 fires a one-cycle internal reset pulse towards the function.

The block also gates the function's memory-mapped register path. The path is a valid/ready request channel and a valid/ready response channel. In D0, requests and responses pass straight through. This includes the debug register window inside the same range, which is flagged to the function. In D3, no request reaches the function. The block accepts the request itself and answers with a master-abort response whose read data is all ones.

The function interrupt is forced low in D3. Wake events are latched into a sticky status bit. That bit drives an internal PME line when its enable bit is set.

Back-pressure rules:
- A request transfers on a cycle with both `req_valid` and `req_ready` high.
- A response transfers on a cycle with both `rsp_valid` and `rsp_ready` high.
- An abort response holds its valid and data until it is taken.
- While an abort response is pending, no new request is accepted.

Top module: `pm_gate_ctrl`

## Requirements
- R1: After reset `cfg_rdata` reads 0 (state D0, PME enable 0, PME status 0), `fn_rst` is 0 and `rsp_valid` is 0.
- R2: A configuration word has the state code in bits [1:0] (00 = D0, 11 = D3), PME enable in bit 2 and PME status write-one-to-clear in bit 3. `cfg_rdata` returns {status, enable, state} in the same positions. A write of 00 or 11 stores that state from the next cycle.
- R3: A write whose state code is 01 or 10 leaves the stored state unchanged. The PME enable and status bits of that write still take effect.
- R4: A write of 00 while the state is 11 drives `fn_rst` high for exactly one cycle: the cycle right after the write edge.
- R5: A write of 00 while in D0, or of 11 while in D3, produces no `fn_rst` pulse.
- R6: In D0 the request fields pass to `fn_req_*`, `req_ready` follows `fn_req_ready`, and the response channel passes through with `rsp_abort` low. `fn_req_dbg` is 1 exactly for addresses in [DBG_BASE, DBG_BASE+DBG_SIZE).
- R7: In D3 `fn_req_valid` stays 0 for every address, including the debug window. A request is accepted while no abort is pending. From the next cycle the block presents `rsp_valid`=1, `rsp_abort`=1 and `rsp_rdata` all ones.
- R8: A pending abort response stays valid and unchanged until `rsp_ready` is 1. While it is pending, `req_ready` is 0.
- R9: In D3 `irq_out` is 0 whatever `fn_irq` shows. In D0 `irq_out` is the OR of `fn_irq`.
- R10: A `fn_wake` pulse sets PME status from the next cycle. A configuration write with bit 3 set clears it, unless a wake event arrives on the same edge.
- R11: `pme_out` is 1 exactly when both PME status and PME enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration write word |
| cfg_rdata | output | 4 | Configuration read word {status, enable, state} |
| fn_rst | output | 1 | One-cycle internal function reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| fn_req_valid | output | 1 | Request valid towards the function |
| fn_req_ready | input | 1 | Function ready for a request |
| fn_req_write | output | 1 | Forwarded write flag |
| fn_req_addr | output | ADDR_W | Forwarded address |
| fn_req_wdata | output | DATA_W | Forwarded write data |
| fn_req_dbg | output | 1 | Address falls in the debug window |
| fn_rsp_valid | input | 1 | Function response valid |
| fn_rsp_ready | output | 1 | Response ready towards the function |
| fn_rsp_rdata | input | DATA_W | Function read data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_rdata | output | DATA_W | Response read data |
| rsp_abort | output | 1 | Response is a master abort |
| fn_irq | input | IRQ_SRCS | Function interrupt sources |
| irq_out | output | 1 | Gated interrupt |
| fn_wake | input | 1 | Wake event from the function |
| pme_out | output | 1 | Internal PME signal |

## Verification
State writes are tried with all four codes, starting from each legal state. This separates real transitions from same-state writes and from dropped codes, and shows whether the reset pulse follows only the D3-to-D0 move. Register traffic is sent with the same addresses (inside and outside the debug window) in both states, and with the response consumer stalled and ready. This tells forwarding apart from aborting and checks that an abort response is held. Interrupt and wake inputs are driven with PME enable both on and off and around a write-one-to-clear, so masking, latching and enabling are each observed on their own.

// File: rtl/pm_gate_pkg.sv
package pm_gate_pkg;
  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D3 = 2'b11
  } pstate_e;

  typedef struct packed {
    logic       sts_w1c;
    logic       pme_en;
    logic [1:0] ps;
  } cfg_word_t;

  function automatic logic ps_legal(input logic [1:0] code);
    return (code == PS_D0) || (code == PS_D3);
  endfunction
endpackage

// File: rtl/pm_state_reg.sv
module pm_state_reg
  import pm_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_ps,
  output logic [1:0] state,
  output logic       fn_rst
);
  logic wake_to_d0;

  assign wake_to_d0 = cfg_wr && (cfg_ps == PS_D0) && (state == PS_D3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PS_D0;
      fn_rst <= 1'b0;
    end else begin
      fn_rst <= wake_to_d0;
      if (cfg_wr && ps_legal(cfg_ps)) state <= cfg_ps;
    end
  end
endmodule

// File: rtl/pm_mmio_gate.sv
module pm_mmio_gate #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int DBG_BASE = 'h0A0,
  parameter int DBG_SIZE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              powered,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              fn_req_valid,
  input  logic              fn_req_ready,
  output logic              fn_req_write,
  output logic [ADDR_W-1:0] fn_req_addr,
  output logic [DATA_W-1:0] fn_req_wdata,
  output logic              fn_req_dbg,
  input  logic              fn_rsp_valid,
  output logic              fn_rsp_ready,
  input  logic [DATA_W-1:0] fn_rsp_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_abort
);
  localparam logic [ADDR_W:0] DBG_LO = (ADDR_W+1)'(DBG_BASE);
  localparam logic [ADDR_W:0] DBG_HI = (ADDR_W+1)'(DBG_BASE + DBG_SIZE);

  logic abort_pend;
  logic take_abort;
  logic [ADDR_W:0] addr_ext;

  assign addr_ext   = {1'b0, req_addr};
  assign fn_req_dbg = (addr_ext >= DBG_LO) && (addr_ext < DBG_HI);

  assign take_abort   = req_valid && !powered && !abort_pend;
  assign fn_req_valid = req_valid && powered && !abort_pend;
  assign fn_req_write = req_write;
  assign fn_req_addr  = req_addr;
  assign fn_req_wdata = req_wdata;
  assign req_ready    = !abort_pend && (powered ? fn_req_ready : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       abort_pend <= 1'b0;
    else if (take_abort)              abort_pend <= 1'b1;
    else if (abort_pend && rsp_ready) abort_pend <= 1'b0;
  end

  assign rsp_valid    = abort_pend || fn_rsp_valid;
  assign rsp_abort    = abort_pend;
  assign rsp_rdata    = abort_pend ? {DATA_W{1'b1}} : fn_rsp_rdata;
  assign fn_rsp_ready = rsp_ready && !abort_pend;
endmodule

// File: rtl/pm_irq_pme.sv
module pm_irq_pme #(
  parameter int IRQ_SRCS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                powered,
  input  logic                cfg_wr,
  input  logic                cfg_en,
  input  logic                cfg_w1c,
  input  logic [IRQ_SRCS-1:0] fn_irq,
  input  logic                fn_wake,
  output logic                irq_out,
  output logic                pme_out,
  output logic                pme_en,
  output logic                pme_sts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pme_en  <= 1'b0;
      pme_sts <= 1'b0;
    end else begin
      if (cfg_wr) pme_en <= cfg_en;
      if (fn_wake)                pme_sts <= 1'b1;
      else if (cfg_wr && cfg_w1c) pme_sts <= 1'b0;
    end
  end

  assign irq_out = powered && (|fn_irq);
  assign pme_out = pme_sts && pme_en;
endmodule

// File: rtl/pm_gate_ctrl.sv
module pm_gate_ctrl
  import pm_gate_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int DBG_BASE = 'h0A0,
  parameter int DBG_SIZE = 16,
  parameter int IRQ_SRCS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [3:0]          cfg_wdata,
  output logic [3:0]          cfg_rdata,
  output logic                fn_rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                fn_req_valid,
  input  logic                fn_req_ready,
  output logic                fn_req_write,
  output logic [ADDR_W-1:0]   fn_req_addr,
  output logic [DATA_W-1:0]   fn_req_wdata,
  output logic                fn_req_dbg,
  input  logic                fn_rsp_valid,
  output logic                fn_rsp_ready,
  input  logic [DATA_W-1:0]   fn_rsp_rdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_abort,
  input  logic [IRQ_SRCS-1:0] fn_irq,
  output logic                irq_out,
  input  logic                fn_wake,
  output logic                pme_out
);
  cfg_word_t  wr_word;
  logic [1:0] state;
  logic       powered;
  logic       pme_en;
  logic       pme_sts;

  assign wr_word = cfg_word_t'(cfg_wdata);
  assign powered = (state == PS_D0);

  pm_state_reg u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_wr (cfg_wr),
    .cfg_ps (wr_word.ps),
    .state  (state),
    .fn_rst (fn_rst)
  );

  pm_mmio_gate #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .DBG_BASE(DBG_BASE),
    .DBG_SIZE(DBG_SIZE)
  ) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .powered      (powered),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .fn_req_valid (fn_req_valid),
    .fn_req_ready (fn_req_ready),
    .fn_req_write (fn_req_write),
    .fn_req_addr  (fn_req_addr),
    .fn_req_wdata (fn_req_wdata),
    .fn_req_dbg   (fn_req_dbg),
    .fn_rsp_valid (fn_rsp_valid),
    .fn_rsp_ready (fn_rsp_ready),
    .fn_rsp_rdata (fn_rsp_rdata),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_rdata    (rsp_rdata),
    .rsp_abort    (rsp_abort)
  );

  pm_irq_pme #(.IRQ_SRCS(IRQ_SRCS)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .powered (powered),
    .cfg_wr  (cfg_wr),
    .cfg_en  (wr_word.pme_en),
    .cfg_w1c (wr_word.sts_w1c),
    .fn_irq  (fn_irq),
    .fn_wake (fn_wake),
    .irq_out (irq_out),
    .pme_out (pme_out),
    .pme_en  (pme_en),
    .pme_sts (pme_sts)
  );

  assign cfg_rdata = {pme_sts, pme_en, state};
endmodule

// File: rtl/pm_gate_chk.sv
module pm_gate_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [3:0]        cfg_wdata,
  input logic [3:0]        cfg_rdata,
  input logic              fn_rst,
  input logic              fn_req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_abort,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              irq_out,
  input logic              pme_out
);
  a_r3_bad_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && (cfg_wdata[1:0] == 2'b01 || cfg_wdata[1:0] == 2'b10)
    |=> cfg_rdata[1:0] == $past(cfg_rdata[1:0]));

  a_r4_wake_reset: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_wdata[1:0] == 2'b00 && cfg_rdata[1:0] == 2'b11 |=> fn_rst);

  a_r5_reset_only_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    fn_rst |-> $past(cfg_rdata[1:0]) == 2'b11 && cfg_rdata[1:0] == 2'b00);

  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    fn_rst |=> !fn_rst);

  a_r7_abort_ones: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_abort |-> rsp_rdata == {DATA_W{1'b1}});

  a_r8_abort_held: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_abort && !rsp_ready |=> rsp_valid && rsp_abort);

  a_r8_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_abort |-> !req_ready);

  a_r7_no_forward_d3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[1:0] == 2'b11 |-> !fn_req_valid);

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[1:0] == 2'b11 |-> !irq_out);

  a_r11_pme_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    pme_out |-> cfg_rdata[2] && cfg_rdata[3]);
endmodule

bind pm_gate_ctrl pm_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr       (cfg_wr),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .fn_rst       (fn_rst),
  .fn_req_valid (fn_req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_abort    (rsp_abort),
  .rsp_rdata    (rsp_rdata),
  .irq_out      (irq_out),
  .pme_out      (pme_out)
);

// File: tb/tb_pm_gate_ctrl.sv
module tb_pm_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int DBG_BASE = 'h0A0;
  localparam int DBG_SIZE = 16;
  localparam int IRQ_SRCS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic [3:0] cfg_rdata;
  logic fn_rst;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic fn_req_valid;
  logic fn_req_ready = 1'b0;
  logic fn_req_write;
  logic [ADDR_W-1:0] fn_req_addr;
  logic [DATA_W-1:0] fn_req_wdata;
  logic fn_req_dbg;
  logic fn_rsp_valid = 1'b0;
  logic fn_rsp_ready;
  logic [DATA_W-1:0] fn_rsp_rdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [DATA_W-1:0] rsp_rdata;
  logic rsp_abort;
  logic [IRQ_SRCS-1:0] fn_irq = '0;
  logic irq_out;
  logic fn_wake = 1'b0;
  logic pme_out;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_gate_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DBG_BASE(DBG_BASE),
    .DBG_SIZE(DBG_SIZE), .IRQ_SRCS(IRQ_SRCS)
  ) dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Drive one configuration write; returns fn_rst seen in the cycle after the edge.
  task automatic cfg_write(input logic [3:0] word, output logic rst_first);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = word;
    @(posedge clk);
    #1;
    rst_first = fn_rst;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset();
    check(cfg_rdata == 4'h0, "R1", "cfg_rdata", 32'(cfg_rdata), 0);
    check(fn_rst == 1'b0, "R1", "fn_rst", 32'(fn_rst), 0);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 0);
  endtask

  task automatic t_state_writes();
    logic r;
    cfg_write(4'b0000, r);
    check(r == 1'b0, "R5", "no reset on D0 to D0", 32'(r), 0);
    check(cfg_rdata[1:0] == 2'b00, "R2", "state after D0 write", 32'(cfg_rdata), 0);
    cfg_write(4'b0011, r);
    check(r == 1'b0, "R5", "no reset on D0 to D3", 32'(r), 0);
    check(cfg_rdata == 4'b0011, "R2", "state after D3 write", 32'(cfg_rdata), 3);
    cfg_write(4'b0011, r);
    check(r == 1'b0, "R5", "no reset on D3 to D3", 32'(r), 0);
  endtask

  task automatic t_bad_codes();
    logic r;
    cfg_write(4'b0001, r);
    check(cfg_rdata == 4'b0011, "R3", "code 01 dropped in D3", 32'(cfg_rdata), 3);
    cfg_write(4'b0110, r);
    check(cfg_rdata == 4'b0111, "R3", "code 10 dropped, enable taken", 32'(cfg_rdata), 7);
    check(r == 1'b0, "R3", "no reset on dropped code", 32'(r), 0);
    cfg_write(4'b0011, r);
    check(cfg_rdata == 4'b0011, "R3", "enable cleared again", 32'(cfg_rdata), 3);
  endtask

  task automatic t_d3_abort();
    @(negedge clk);
    fn_req_ready = 1'b1;
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr = 12'h010;
    #1;
    check(fn_req_valid == 1'b0, "R7", "no forward in D3", 32'(fn_req_valid), 0);
    check(req_ready == 1'b1, "R7", "D3 accepts request", 32'(req_ready), 1);
    @(posedge clk);
    #1;
    check(rsp_valid && rsp_abort, "R7", "abort response", 32'({rsp_valid, rsp_abort}), 3);
    check(rsp_rdata == '1, "R7", "abort data all ones", rsp_rdata, 32'hFFFF_FFFF);
    check(req_ready == 1'b0, "R8", "no accept while pending", 32'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    check(rsp_valid && rsp_abort, "R8", "abort held while stalled", 32'({rsp_valid, rsp_abort}), 3);
    @(negedge clk);
    rsp_ready = 1'b1;
    @(posedge clk);
    #1;
    check(rsp_valid == 1'b0, "R8", "abort cleared when taken", 32'(rsp_valid), 0);
    // debug window in D3, write access
    @(negedge clk);
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr = 12'(DBG_BASE + 4);
    req_wdata = 32'hDEAD_0001;
    #1;
    check(fn_req_valid == 1'b0, "R7", "debug window blocked in D3", 32'(fn_req_valid), 0);
    @(posedge clk);
    #1;
    check(rsp_abort == 1'b1, "R7", "debug window aborted", 32'(rsp_abort), 1);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    check(rsp_valid == 1'b0, "R8", "second abort taken", 32'(rsp_valid), 0);
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_irq_d3();
    @(negedge clk);
    fn_irq = 2'b10;
    #1;
    check(irq_out == 1'b0, "R9", "irq masked in D3", 32'(irq_out), 0);
  endtask

  task automatic t_pme_and_exit();
    logic r;
    @(negedge clk);
    fn_wake = 1'b1;
    @(negedge clk);
    fn_wake = 1'b0;
    #1;
    check(cfg_rdata[3] == 1'b1, "R10", "wake latched", 32'(cfg_rdata), 32'h8);
    check(pme_out == 1'b0, "R11", "pme off without enable", 32'(pme_out), 0);
    cfg_write(4'b0111, r);
    check(pme_out == 1'b1, "R11", "pme on with enable", 32'(pme_out), 1);
    cfg_write(4'b1111, r);
    check(cfg_rdata == 4'b0111, "R10", "status cleared by one", 32'(cfg_rdata), 7);
    check(pme_out == 1'b0, "R11", "pme off after clear", 32'(pme_out), 0);
    // wake and clear on the same edge: set wins
    @(negedge clk);
    fn_wake = 1'b1;
    cfg_wr = 1'b1;
    cfg_wdata = 4'b1111;
    @(negedge clk);
    fn_wake = 1'b0;
    cfg_wr = 1'b0;
    #1;
    check(cfg_rdata[3] == 1'b1, "R10", "set wins over clear", 32'(cfg_rdata), 32'hF);
    cfg_write(4'b0100, r);
    check(r == 1'b1, "R4", "reset pulse on D3 to D0", 32'(r), 1);
    check(cfg_rdata[1:0] == 2'b00, "R2", "state D0", 32'(cfg_rdata), 0);
    @(posedge clk);
    #1;
    check(fn_rst == 1'b0, "R4", "reset pulse one cycle", 32'(fn_rst), 0);
    check(irq_out == 1'b1, "R9", "irq passes in D0", 32'(irq_out), 1);
    @(negedge clk);
    fn_irq = '0;
  endtask

  task automatic t_d0_pass();
    @(negedge clk);
    fn_req_ready = 1'b0;
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr = 12'h123;
    req_wdata = 32'hCAFE_5A5A;
    #1;
    check(fn_req_valid == 1'b1, "R6", "forward in D0", 32'(fn_req_valid), 1);
    check(req_ready == 1'b0, "R6", "ready follows function", 32'(req_ready), 0);
    check(fn_req_addr == 12'h123 && fn_req_wdata == 32'hCAFE_5A5A && fn_req_write,
          "R6", "fields forwarded", fn_req_wdata, 32'hCAFE_5A5A);
    check(fn_req_dbg == 1'b0, "R6", "outside debug window", 32'(fn_req_dbg), 0);
    fn_req_ready = 1'b1;
    req_addr = 12'(DBG_BASE + DBG_SIZE - 1);
    #1;
    check(req_ready == 1'b1, "R6", "ready high with function", 32'(req_ready), 1);
    check(fn_req_dbg == 1'b1, "R6", "last debug address flagged", 32'(fn_req_dbg), 1);
    req_addr = 12'(DBG_BASE + DBG_SIZE);
    #1;
    check(fn_req_dbg == 1'b0, "R6", "past debug window", 32'(fn_req_dbg), 0);
    @(negedge clk);
    req_valid = 1'b0;
    fn_rsp_valid = 1'b1;
    fn_rsp_rdata = 32'h0000_1234;
    rsp_ready = 1'b1;
    #1;
    check(rsp_valid && !rsp_abort && rsp_rdata == 32'h1234, "R6", "response passes",
          rsp_rdata, 32'h1234);
    check(fn_rsp_ready == 1'b1, "R6", "response ready passes", 32'(fn_rsp_ready), 1);
    @(negedge clk);
    fn_rsp_valid = 1'b0;
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_state_writes();
    t_bad_codes();
    t_d3_abort();
    t_irq_d3();
    t_pme_and_exit();
    t_d0_pass();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule